// File: doc/BRIEF.md
# Page Access Permission Checker

This block judges a single memory access against the attribute bits of one page table entry. Each request brings the entry's present, writable and user-accessible bits, the access direction, the current privilege level and a virtual-mode flag. One clock later the block answers with exactly one of two strobes: a grant, which lets the access proceed, or a fault, which comes with an error-code vector that describes the cause.

Privilege levels at or above a threshold count as user level, and the rest count as supervisor level. While the virtual-mode flag is set, every access is treated as user level, whatever privilege level is presented. A page that is not present traps both reads and writes. A read-only page traps only writes. A hypervisor-style monitor can therefore catch device accesses by marking the page either absent or read-only, and can later clear the trap so that accesses run at full speed. Page walking, translation caching and fault handling are done elsewhere.

Top module: `page_perm_check`

## Requirements
- R1: After reset, and until the first request, grant_o and fault_o are low and err_o is zero.
- R2: Each cycle in which req_i is high is followed, one cycle later, by exactly one of grant_o and fault_o. Neither strobe is raised in the cycle after a cycle in which req_i is low.
- R3: A request with present_i low faults, for a read (wr_i=0) and for a write (wr_i=1) alike.
- R4: A request to a present page with writable_i low faults when wr_i=1 and is granted when wr_i=0, provided the privilege check passes.
- R5: A user-level request to a page with user_page_i low (supervisor only) faults.
- R6: Privilege levels 0, 1 and 2 (cpl_i below 3) act as supervisor level and may access pages with user_page_i low.
- R7: When vm_i is high, the request is treated as user level (privilege 3) whatever the value of cpl_i.
- R8: On a fault, err_o[0] is the present bit, err_o[1] is 1 for a write, err_o[2] is 1 for a user-level access, and the upper bits are 0. On a grant, and in idle cycles, err_o is zero.
- R9: The not-present check comes before the privilege and write checks: a not-present page reports err_o[0]=0, even when the privilege check or the write check would also fail.
- R10: A present, writable page that the privilege level is allowed to use is granted for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe; the inputs below are valid while it is high |
| present_i | input | 1 | Entry present bit |
| writable_i | input | 1 | Entry writable bit (0 = read-only) |
| user_page_i | input | 1 | Entry user bit (0 = supervisor only) |
| wr_i | input | 1 | Access direction, 1 = write |
| cpl_i | input | CPL_W | Current privilege level |
| vm_i | input | 1 | Virtual-mode flag, which forces user level |
| grant_o | output | 1 | Access allowed, one cycle after the request |
| fault_o | output | 1 | Page fault, one cycle after the request |
| err_o | output | ERR_W | Fault cause code, valid while fault_o is high |

## Verification
The bench sends all 128 combinations of the present, writable, user and direction bits, the four privilege levels and the virtual-mode flag. Its behavioural model tells each of the separate fault causes from a grant and checks the cause bits of every fault. Two cases are kept apart: virtual mode with a supervisor-level privilege must behave like privilege 3, and an absent page must win over a failing privilege or write check. The same combinations are then sent back to back and with idle gaps between them, which shows that a response belongs only to the request of the cycle before.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

   // Attribute bits of one page table entry plus the access direction
   typedef struct packed {
      logic present;
      logic writable;
      logic user_page;
      logic wr;
   } pchk_acc_t;

   // Positions of the cause bits inside the error code
   localparam int unsigned ERR_PRESENT_BIT = 0;
   localparam int unsigned ERR_WRITE_BIT   = 1;
   localparam int unsigned ERR_USER_BIT    = 2;
   localparam int unsigned ERR_MIN_W       = 3;

endpackage

// File: rtl/pchk_priv_resolve.sv
// Decides whether an access runs at user level
module pchk_priv_resolve #(
   parameter int unsigned CPL_W     = 2,
   parameter int unsigned USER_CPL  = 3,
   parameter bit          VM_FORCE  = 1'b1
) (
   input  logic [CPL_W-1:0] cpl_i,
   input  logic             vm_i,
   output logic             is_user_o
);
   localparam logic [CPL_W-1:0] USER_LVL = CPL_W'(USER_CPL);

   logic by_level;

   generate
      if (USER_CPL >= (1 << CPL_W)) begin : g_bad_cpl
         $error("USER_CPL does not fit in CPL_W bits");
      end
   endgenerate

   assign by_level = (cpl_i >= USER_LVL);

   generate
      if (VM_FORCE) begin : g_vm_force
         assign is_user_o = by_level | vm_i;
      end else begin : g_vm_pass
         logic vm_unused;
         assign vm_unused = vm_i;
         assign is_user_o = by_level & ~(vm_unused & 1'b0);
      end
   endgenerate
endmodule

// File: rtl/pchk_decide.sv
// Combinational permission decision and cause encoding
module pchk_decide
   import pchk_pkg::*;
#(
   parameter int unsigned ERR_W = 3
) (
   input  pchk_acc_t        acc_i,
   input  logic             is_user_i,
   output logic             ok_o,
   output logic [ERR_W-1:0] err_o
);
   generate
      if (ERR_W < ERR_MIN_W) begin : g_bad_err
         $error("ERR_W must be at least 3");
      end
   endgenerate

   logic priv_fail;
   logic write_fail;

   always_comb begin
      priv_fail  = is_user_i & ~acc_i.user_page;
      write_fail = acc_i.wr & ~acc_i.writable;
      // absence is checked first; the other two only matter for present pages
      if (!acc_i.present) begin
         ok_o = 1'b0;
      end else if (priv_fail) begin
         ok_o = 1'b0;
      end else if (write_fail) begin
         ok_o = 1'b0;
      end else begin
         ok_o = 1'b1;
      end
      err_o                  = '0;
      err_o[ERR_PRESENT_BIT] = acc_i.present;
      err_o[ERR_WRITE_BIT]   = acc_i.wr;
      err_o[ERR_USER_BIT]    = is_user_i;
   end
endmodule

// File: rtl/pchk_resp_reg.sv
// Response stage: one-cycle registered strobes and error code
module pchk_resp_reg #(
   parameter int unsigned ERR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             ok_i,
   input  logic [ERR_W-1:0] err_i,
   output logic             grant_o,
   output logic             fault_o,
   output logic [ERR_W-1:0] err_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_o <= 1'b0;
         fault_o <= 1'b0;
         err_o   <= '0;
      end else begin
         grant_o <= req_i & ok_i;
         fault_o <= req_i & ~ok_i;
         err_o   <= (req_i & ~ok_i) ? err_i : '0;
      end
   end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
   import pchk_pkg::*;
#(
   parameter int unsigned CPL_W    = 2,
   parameter int unsigned USER_CPL = 3,
   parameter int unsigned ERR_W    = 3,
   parameter bit          VM_FORCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             present_i,
   input  logic             writable_i,
   input  logic             user_page_i,
   input  logic             wr_i,
   input  logic [CPL_W-1:0] cpl_i,
   input  logic             vm_i,
   output logic             grant_o,
   output logic             fault_o,
   output logic [ERR_W-1:0] err_o
);
   pchk_acc_t        acc;
   logic             is_user;
   logic             ok;
   logic [ERR_W-1:0] err_c;

   assign acc = '{present: present_i, writable: writable_i,
                  user_page: user_page_i, wr: wr_i};

   pchk_priv_resolve #(
      .CPL_W   (CPL_W),
      .USER_CPL(USER_CPL),
      .VM_FORCE(VM_FORCE)
   ) i_priv (
      .cpl_i    (cpl_i),
      .vm_i     (vm_i),
      .is_user_o(is_user)
   );

   pchk_decide #(
      .ERR_W(ERR_W)
   ) i_decide (
      .acc_i    (acc),
      .is_user_i(is_user),
      .ok_o     (ok),
      .err_o    (err_c)
   );

   pchk_resp_reg #(
      .ERR_W(ERR_W)
   ) i_resp (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .ok_i   (ok),
      .err_i  (err_c),
      .grant_o(grant_o),
      .fault_o(fault_o),
      .err_o  (err_o)
   );
endmodule

// File: rtl/page_perm_check_chk.sv
module page_perm_check_chk #(
   parameter int unsigned CPL_W = 2,
   parameter int unsigned ERR_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_i,
   input logic             present_i,
   input logic             writable_i,
   input logic             user_page_i,
   input logic             wr_i,
   input logic [CPL_W-1:0] cpl_i,
   input logic             vm_i,
   input logic             grant_o,
   input logic             fault_o,
   input logic [ERR_W-1:0] err_o
);
   // R2
   resp_exactly_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> (grant_o ^ fault_o));
   // R2
   no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!grant_o && !fault_o));
   // R3
   absent_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !present_i) |=> (fault_o && !err_o[0]));
   // R4
   readonly_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && wr_i && !writable_i) |=> (fault_o && err_o[1]));
   // R7
   vm_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && vm_i && present_i && !user_page_i) |=> (fault_o && err_o[2]));
   // R6
   super_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !vm_i && (cpl_i < CPL_W'(3)) && present_i && writable_i) |=> grant_o);
   // R8
   grant_clean_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_o) |-> (err_o == '0));
endmodule

bind page_perm_check page_perm_check_chk #(.CPL_W(CPL_W), .ERR_W(ERR_W)) i_chk (.*);

// File: tb/test_page_perm_check.sv
module test_page_perm_check;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_i = 1'b0;
   logic       present_i = 1'b0;
   logic       writable_i = 1'b0;
   logic       user_page_i = 1'b0;
   logic       wr_i = 1'b0;
   logic [1:0] cpl_i = 2'd0;
   logic       vm_i = 1'b0;
   logic       grant_o;
   logic       fault_o;
   logic [2:0] err_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // expected response for the request applied one cycle earlier
   logic       exp_grant = 1'b0;
   logic       exp_fault = 1'b0;
   logic [2:0] exp_err = 3'd0;
   string      exp_tag = "R2";

   always #2 clk = ~clk;

   page_perm_check i_page_perm_check (.*);

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got grant/fault/err=%b expected %b", tag, act, exp);
      end
   endtask

   // behavioural model of one request
   task automatic predict(input bit rq, input bit p, input bit w, input bit u,
                          input bit wr, input int cpl, input bit vm);
      bit user;
      user = vm || (cpl >= 3);
      exp_grant = 1'b0; exp_fault = 1'b0; exp_err = 3'd0;
      if (!rq) begin
         exp_tag = "R2";
      end else if (!p) begin
         exp_fault = 1'b1;
         exp_tag = (u && !(wr && !w)) ? "R3" : "R9";
      end else if (user && !u) begin
         exp_fault = 1'b1;
         exp_tag = (vm && cpl < 3) ? "R7" : "R5";
      end else if (wr && !w) begin
         exp_fault = 1'b1;
         exp_tag = "R4";
      end else begin
         exp_grant = 1'b1;
         exp_tag = (!u && cpl < 3) ? "R6" : (w ? "R10" : "R4");
      end
      if (exp_fault) exp_err = {user, wr, p};
   endtask

   // compare last cycle's prediction, then drive the next request
   task automatic step(input bit rq, input bit p, input bit w, input bit u,
                       input bit wr, input int cpl, input bit vm);
      @(negedge clk);
      check(exp_tag, {grant_o, fault_o, err_o}, {exp_grant, exp_fault, exp_err});
      if (exp_fault) check("R8", {2'b00, err_o}, {2'b00, exp_err});
      req_i = rq; present_i = p; writable_i = w; user_page_i = u;
      wr_i = wr; cpl_i = 2'(cpl); vm_i = vm;
      predict(rq, p, w, u, wr, cpl, vm);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state before any request
      check("R1", {grant_o, fault_o, err_o}, 5'b0);
      // exhaustive, back to back
      for (int k = 0; k < 128; k++)
         step(1'b1, k[0], k[1], k[2], k[3], int'(k[5:4]), k[6]);
      // exhaustive, reversed order with idle gaps (garbage on inputs while idle)
      for (int k = 127; k >= 0; k--) begin
         step(1'b1, k[0], k[1], k[2], k[3], int'(k[5:4]), k[6]);
         step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3, 1'b1);
      end
      // targeted corners
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b1); // R9 absent wins over all
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b1); // R7 vm forces user
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2, 1'b0); // R6 level 2 supervisor
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3, 1'b0); // R10 user write
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule